// File: doc/BRIEF.md
# AC-Inverting Segment Output Selector

This block sits at the back end of a dot-matrix segment driver. It holds one full display line in an output latch and turns every latched bit into a 2-bit level code. Each code selects one of three drive levels: V0, VM or V1. Analog switches downstream act on these codes.

The output latch takes the whole captured line from the capture stage when the line-latch strobe falls. That falling edge is detected on the system clock. Between strobes the latch holds its value.

Each code is formed from four things:
- the latched bit,
- the frame AC polarity input, which inverts the drive on alternate frames so the panel sees no DC,
- a display enable input, which forces the mid level when it is low,
- a mode input, which narrows the active window to the centre outputs.

The polarity input is not registered. A change in polarity therefore flips every output at once, with no new strobe needed.

Top module: `seg_out_sel`

## Requirements
- R1: On the first clock edge at which `latch_strobe_i` is seen low after having been high, the whole of `line_data_i` is loaded into the output latch. The codes reflect the new line right after that edge.
- R2: With the display enabled, an output whose effective bit equals `polarity_i` gives code 2'b10 (V1). An output whose effective bit differs from `polarity_i` gives code 2'b00 (V0). Bit value 1 means on and 0 means off.
- R3: While `disp_on_i` is low, every output gives code 2'b01 (VM), whatever the latch, polarity and mode are.
- R4: The forcing in R3 also holds while the data, strobe, polarity and mode inputs are unknown (X).
- R5: While `full_mode_i` is low, outputs with index 0–39 and 280–319 use an effective bit of 0. They give 2'b10 when polarity is 0 and 2'b00 when polarity is 1.
- R6: A change of `polarity_i` changes the codes without any strobe, and the latch is left as it was.
- R7: Reset clears the output latch to all zeros.
- R8: A rising strobe, a strobe held low, and changes on `line_data_i` without a falling strobe all leave the latch unchanged.
- R9: While `full_mode_i` is high, every output follows its own latched bit under R2. Output index g is driven by bit g of the captured line, in code bits [2g+1:2g].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| line_data_i | input | 320 | Captured line from the capture stage |
| latch_strobe_i | input | 1 | Line-latch strobe; its falling edge loads the line |
| polarity_i | input | 1 | Frame AC polarity |
| disp_on_i | input | 1 | Display enable; low forces every output to VM |
| full_mode_i | input | 1 | 1 = all 320 outputs active, 0 = centre 240 active |
| level_o | output | 640 | Packed level codes, two bits per output |

## Verification
A wrong latch bit shows up on one output code in the very cycle after the strobe edge that loaded it, and it stays there until the next falling strobe. The bench compares all 320 codes against its own model of the line.

A latch that loads on the wrong edge, or reloads while the strobe is held low, shows up after the bench changes the line data without a falling strobe. Faults in the polarity path show up combinationally, in the same cycle as the change. Faults in the display-off path and the blank windows also show up in that same cycle.

// File: rtl/seg_out_pkg.sv
package seg_out_pkg;
  typedef enum logic [1:0] {
    LVL_V0 = 2'b00,
    LVL_VM = 2'b01,
    LVL_V1 = 2'b10
  } lvl_e;
endpackage

// File: rtl/strobe_fall_det.sv
module strobe_fall_det (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic strobe_i,
  output logic fall_o
);
  logic strobe_q;

  // reset low so no spurious fall is seen straight after reset
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) strobe_q <= 1'b0;
    else         strobe_q <= strobe_i;
  end

  assign fall_o = strobe_q & ~strobe_i;
endmodule

// File: rtl/line_latch.sv
module line_latch #(
  parameter int unsigned WIDTH = 320
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [WIDTH-1:0] data_i,
  output logic [WIDTH-1:0] line_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     line_o <= '0;
    else if (load_i) line_o <= data_i;
  end

  AST_LATCH_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> line_o == $past(data_i)); // R1
  AST_LATCH_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> $stable(line_o)); // R8
endmodule

// File: rtl/seg_level_cell.sv
module seg_level_cell
  import seg_out_pkg::*;
(
  input  logic       bit_i,
  input  logic       pol_i,
  input  logic       disp_on_i,
  input  logic       blank_i,
  output logic [1:0] code_o
);
  logic eff;
  lvl_e lvl;

  assign eff = bit_i & ~blank_i;

  always_comb begin
    if (!disp_on_i)     lvl = LVL_VM;
    else if (eff ^ pol_i) lvl = LVL_V0;
    else                lvl = LVL_V1;
  end

  assign code_o = lvl;
endmodule

// File: rtl/seg_out_sel.sv
module seg_out_sel
  import seg_out_pkg::*;
#(
  parameter int unsigned NUM_OUT  = 320,
  parameter int unsigned EDGE_OFF = 40
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic [NUM_OUT-1:0]     line_data_i,
  input  logic                   latch_strobe_i,
  input  logic                   polarity_i,
  input  logic                   disp_on_i,
  input  logic                   full_mode_i,
  output logic [2*NUM_OUT-1:0]   level_o
);
  localparam int unsigned HI_EDGE = NUM_OUT - EDGE_OFF;

  logic               load;
  logic [NUM_OUT-1:0] line_q;

  strobe_fall_det u_fall (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .strobe_i(latch_strobe_i),
    .fall_o  (load)
  );

  line_latch #(.WIDTH(NUM_OUT)) u_latch (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .load_i(load),
    .data_i(line_data_i),
    .line_o(line_q)
  );

  for (genvar g = 0; g < NUM_OUT; g++) begin : g_out
    localparam bit IS_EDGE = (g < EDGE_OFF) || (g >= HI_EDGE);
    logic blank;

    if (IS_EDGE) begin : g_edge
      assign blank = ~full_mode_i;
      AST_BLANK_ZONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (disp_on_i && !full_mode_i) |->
          level_o[2*g +: 2] == (polarity_i ? LVL_V0 : LVL_V1)); // R5
    end else begin : g_mid
      assign blank = 1'b0;
    end

    seg_level_cell u_cell (
      .bit_i    (line_q[g]),
      .pol_i    (polarity_i),
      .disp_on_i(disp_on_i),
      .blank_i  (blank),
      .code_o   (level_o[2*g +: 2])
    );
  end

  AST_DISP_FORCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !disp_on_i |-> level_o == {NUM_OUT{LVL_VM}}); // R3
  AST_POL_SWAP_KEEPS_LINE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (polarity_i != $past(polarity_i) && !load) |=> $stable(line_q)); // R6
endmodule

// File: tb/seg_out_sel_tb_top.sv
module seg_out_sel_tb_top;
  localparam int N = 320;

  logic           clk_i = 1'b0;
  logic           rst_ni = 1'b0;
  logic [N-1:0]   line_data_i = '0;
  logic           latch_strobe_i = 1'b0;
  logic           polarity_i = 1'b0;
  logic           disp_on_i = 1'b1;
  logic           full_mode_i = 1'b1;
  logic [2*N-1:0] level_o;

  int errors = 0;
  int checks = 0;
  bit done = 0;
  logic [N-1:0] exp_line = '0;

  always #10 clk_i = ~clk_i;

  seg_out_sel dut_i (.*);

  function automatic logic [1:0] exp_code(int i, logic d, logic m, logic on, logic full);
    logic eff;
    if (!on) return 2'b01;
    eff = d && !(!full && (i < 40 || i >= 280));
    return (eff == m) ? 2'b10 : 2'b00;
  endfunction

  function automatic logic [N-1:0] rand_line();
    logic [N-1:0] v;
    for (int k = 0; k < N / 32; k++) v[k*32 +: 32] = $urandom;
    return v;
  endfunction

  task automatic check_all(string req, logic on_model);
    int bad = 0;
    logic [1:0] e;
    checks++;
    for (int i = 0; i < N; i++) begin
      e = exp_code(i, exp_line[i], polarity_i, on_model, full_mode_i);
      if (level_o[2*i +: 2] !== e) begin
        if (bad == 0)
          $display("FAIL %s out[%0d] actual=%b expected=%b", req, i, level_o[2*i +: 2], e);
        bad++;
      end
    end
    if (bad != 0) errors++;
  endtask

  // falling strobe, model updated at the loading edge
  task automatic latch_line(logic [N-1:0] v);
    @(negedge clk_i); latch_strobe_i = 1'b1; line_data_i = v;
    @(negedge clk_i); latch_strobe_i = 1'b0;
    @(negedge clk_i); exp_line = v;
  endtask

  initial begin
    void'($urandom(32'h5eed_0042));
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    polarity_i = 1'b0; #1; check_all("R7 reset M=0", 1'b1);
    polarity_i = 1'b1; #1; check_all("R7 reset M=1", 1'b1);

    latch_line('1);
    polarity_i = 1'b0; #1; check_all("R2 all on M=0", 1'b1);
    polarity_i = 1'b1; #1; check_all("R2 all on M=1", 1'b1);

    for (int t = 0; t < 8; t++) begin
      latch_line(rand_line());
      polarity_i = $urandom_range(0, 1);
      #1; check_all("R9 random line", 1'b1);
      @(negedge clk_i); polarity_i = ~polarity_i;
      #1; check_all("R6 polarity flip", 1'b1);
    end

    // R8: data change, rising strobe, held low
    @(negedge clk_i); line_data_i = ~exp_line;
    @(negedge clk_i); #1; check_all("R8 data change no strobe", 1'b1);
    latch_strobe_i = 1'b1;
    @(negedge clk_i); @(negedge clk_i); #1; check_all("R8 rising strobe", 1'b1);
    latch_line(rand_line());
    line_data_i = rand_line();
    repeat (4) @(negedge clk_i); #1; check_all("R8 strobe held low", 1'b1);
    check_all("R1 load on falling strobe", 1'b1);

    // R5 reduced mode
    latch_line('1);
    full_mode_i = 1'b0;
    for (int p = 0; p < 2; p++) begin
      polarity_i = p[0]; #1; check_all("R5 reduced all on", 1'b1);
    end
    latch_line(rand_line());
    polarity_i = $urandom_range(0, 1); #1; check_all("R5 reduced random", 1'b1);
    full_mode_i = 1'b1; #1; check_all("R9 back to full", 1'b1);

    // R3 display off
    disp_on_i = 1'b0;
    for (int t = 0; t < 3; t++) begin
      @(negedge clk_i);
      polarity_i = $urandom_range(0, 1); full_mode_i = $urandom_range(0, 1);
      #1; check_all("R3 display off", 1'b0);
    end
    latch_line(rand_line());
    #1; check_all("R3 display off after load", 1'b0);

    // R4 unknown inputs while off
    @(negedge clk_i);
    line_data_i = 'x; polarity_i = 1'bx; full_mode_i = 1'bx; latch_strobe_i = 1'bx;
    @(negedge clk_i); #1;
    checks++;
    if (level_o !== {N{2'b01}}) begin
      errors++;
      $display("FAIL R4 actual=%h expected=all VM", level_o);
    end
    polarity_i = 1'b0; full_mode_i = 1'b1;

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=running expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule